// File: doc/BRIEF.md
# Serial ADC command-frame controller

This block is the host-side master for a converter that talks over a 16-bit framed serial link. A local requester hands it a 4-bit command word, an optional 12-bit configuration word, a sampling-length choice and a trigger style. The controller opens a frame by pulling chip select low. In frame-sync style it also raises a frame-sync strobe for the set-up half period. It then toggles the serial clock at a rate set by a divider parameter and shifts the command out on the data-in line, followed by the configuration word or zeros. At the same time it reads back the converter's previous conversion result from the data-out line.

A frame is 16 serial clocks for short sampling or 48 for long sampling. After the last clock the controller releases chip select. It then waits out the conversion time, counted in serial-clock periods, before it accepts the next request. Requests are taken through a valid/ready handshake, so a request that arrives during a frame or a conversion wait simply waits.

Top module: `adc_frame_ctrl`

## Requirements
- R1: While reset is high and directly after it, cs_n is 1, sclk is 0, sdi is 0, fs is 0, result_valid is 0 and req_ready is 1.
- R2: A request is taken only in a cycle with req_valid and req_ready both high. req_ready is low from the cycle after acceptance until the conversion wait ends. Each fall of cs_n corresponds to exactly one accepted request, in order.
- R3: After acceptance, cs_n falls and sclk stays low for DIV system cycles before its first rising edge. With req_fs_mode=1, fs is 1 when cs_n falls and returns to 0 on the first rising edge. With req_fs_mode=0, fs stays 0.
- R4: The value of sdi at the first four sclk rising edges is req_cmd, most significant bit first.
- R5: At rising edges 5 to 16, sdi carries req_cfg most significant bit first when req_cmd equals 4'b1010. For any other command, sdi is 0 at those edges.
- R6: A frame has 16 sclk rising edges when req_long=0 and 48 when req_long=1. sdi is 0 at every edge after the 16th, and cs_n stays low for the whole frame.
- R7: Each sclk half period lasts DIV system cycles, so rising edges within a frame are 2*DIV cycles apart.
- R8: sdo is sampled on each sclk rising edge. The bits seen at the first 14 edges, most significant first, form result_data. result_valid is high for exactly one cycle per frame, in the cycle that follows the 14th rising edge.
- R9: cs_n rises DIV cycles after the last rising edge. req_ready then returns to 1 exactly 2*CONV_CLKS*DIV system cycles after cs_n rose.
- R10: Whenever cs_n is 1, sclk and sdi are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_cmd | input | CMD_W | Command code sent in the command period |
| req_cfg | input | CFG_W | Configuration word, sent only with the configuration-write command |
| req_long | input | 1 | 1 selects the long sampling window |
| req_fs_mode | input | 1 | 1 selects frame-sync triggering |
| cs_n | output | 1 | Chip select, active low |
| fs | output | 1 | Frame-sync strobe |
| sclk | output | 1 | Serial clock, idle low |
| sdi | output | 1 | Serial data to the converter |
| sdo | input | 1 | Serial data from the converter |
| result_valid | output | 1 | One-cycle strobe for a captured result |
| result_data | output | RES_W | Captured result of the previous conversion |

## Verification
The embedded properties check several rules on every cycle. Serial clock activity happens only under chip select, and sdi and sclk are quiet when chip select is high. A serial clock high phase never lasts a single cycle. The result strobe never lasts two cycles. Acceptance drops ready at once, and ready stays low right after chip select rises. Only the bench scenarios can show the serial contents and the exact spacings: command and configuration bits in their positions, zero fill for other commands and long frames, edge counts for each sampling length, setup and half-period durations, the exact conversion wait, and the captured result for extreme and mixed words.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_CONV
  } seq_state_t;

endpackage

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == LAST);

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adc_frame_pkg::*;
#(
  parameter int CMD_W      = 4,
  parameter int SHORT_SAMP = 12,
  parameter int LONG_SAMP  = 44,
  parameter int CONV_CLKS  = 72,
  parameter int RES_W      = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_long,
  input  logic req_fs_mode,
  input  logic tick,
  output logic run,
  output logic req_ready,
  output logic cs_n,
  output logic sclk,
  output logic fs,
  output logic load_stb,
  output logic rise_stb,
  output logic fall_stb,
  output logic end_stb,
  output logic res_stb
);

  localparam int SHORT_LEN  = CMD_W + SHORT_SAMP;
  localparam int LONG_LEN   = CMD_W + LONG_SAMP;
  localparam int BW         = $clog2(LONG_LEN);
  localparam int CONV_TICKS = 2 * CONV_CLKS;
  localparam int KW         = $clog2(CONV_TICKS);

  seq_state_t    state;
  logic [BW-1:0] bit_cnt;
  logic [KW-1:0] conv_cnt;
  logic          long_q;
  logic [BW-1:0] last_bit;
  logic          at_last;

  assign last_bit = long_q ? BW'(LONG_LEN - 1) : BW'(SHORT_LEN - 1);
  assign at_last  = (bit_cnt == last_bit);
  assign run      = (state != ST_IDLE);
  assign load_stb = (state == ST_IDLE) && req_valid;
  assign rise_stb = tick && ((state == ST_SETUP) || (state == ST_LOW));
  assign fall_stb = tick && (state == ST_HIGH) && !at_last;
  assign end_stb  = tick && (state == ST_HIGH) && at_last;
  assign res_stb  = rise_stb && (bit_cnt == BW'(RES_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      conv_cnt  <= '0;
      long_q    <= 1'b0;
      req_ready <= 1'b1;
      cs_n      <= 1'b1;
      sclk      <= 1'b0;
      fs        <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            state     <= ST_SETUP;
            bit_cnt   <= '0;
            long_q    <= req_long;
            req_ready <= 1'b0;
            cs_n      <= 1'b0;
            fs        <= req_fs_mode;
          end
        end
        ST_SETUP: begin
          if (tick) begin
            state <= ST_HIGH;
            sclk  <= 1'b1;
            fs    <= 1'b0;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            sclk <= 1'b0;
            if (at_last) begin
              state    <= ST_CONV;
              cs_n     <= 1'b1;
              conv_cnt <= '0;
            end else begin
              state   <= ST_LOW;
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        ST_LOW: begin
          if (tick) begin
            state <= ST_HIGH;
            sclk  <= 1'b1;
          end
        end
        ST_CONV: begin
          if (tick) begin
            if (conv_cnt == KW'(CONV_TICKS - 1)) begin
              state     <= ST_IDLE;
              req_ready <= 1'b1;
            end else begin
              conv_cnt <= conv_cnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: serial clock activity only inside an open frame
  p_sclk_in_frame_r6: assert property (@(posedge clk) disable iff (rst)
    sclk |-> !cs_n);

  // R2: acceptance takes the controller out of idle at once
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R7: a high phase lasts more than one system cycle
  p_high_phase_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |=> sclk);

  // R9: releasing chip select starts the conversion wait, not idle
  p_conv_hold_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |=> !req_ready);

  // R2: idle means no frame is open
  p_ready_idle_r2: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> cs_n);

endmodule

// File: rtl/adc_shift_unit.sv
module adc_shift_unit #(
  parameter int CMD_W = 4,
  parameter int CFG_W = 12,
  parameter int RES_W = 14,
  parameter logic [CMD_W-1:0] CFG_CMD = CMD_W'(10)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_stb,
  input  logic [CMD_W-1:0] req_cmd,
  input  logic [CFG_W-1:0] req_cfg,
  input  logic             fall_stb,
  input  logic             end_stb,
  input  logic             rise_stb,
  input  logic             res_stb,
  input  logic             sdo,
  output logic             sdi,
  output logic             result_valid,
  output logic [RES_W-1:0] result_data
);

  localparam int TW = CMD_W + CFG_W;

  logic [TW-1:0]    tx;
  logic [RES_W-2:0] rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx <= '0;
    end else if (load_stb) begin
      tx <= {req_cmd, (req_cmd == CFG_CMD) ? req_cfg : {CFG_W{1'b0}}};
    end else if (end_stb) begin
      tx <= '0;
    end else if (fall_stb) begin
      tx <= {tx[TW-2:0], 1'b0};
    end
  end

  assign sdi = tx[TW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rx           <= '0;
      result_data  <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= res_stb;
      if (rise_stb) begin
        rx <= {rx[RES_W-3:0], sdo};
      end
      if (res_stb) begin
        result_data <= {rx, sdo};
      end
    end
  end

  // R8: the result strobe is a single-cycle pulse
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl #(
  parameter int DIV        = 4,
  parameter int CMD_W      = 4,
  parameter int CFG_W      = 12,
  parameter int RES_W      = 14,
  parameter int SHORT_SAMP = 12,
  parameter int LONG_SAMP  = 44,
  parameter int CONV_CLKS  = 72,
  parameter logic [CMD_W-1:0] CFG_CMD = CMD_W'(10)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CMD_W-1:0] req_cmd,
  input  logic [CFG_W-1:0] req_cfg,
  input  logic             req_long,
  input  logic             req_fs_mode,
  output logic             cs_n,
  output logic             fs,
  output logic             sclk,
  output logic             sdi,
  input  logic             sdo,
  output logic             result_valid,
  output logic [RES_W-1:0] result_data
);

  logic run, tick;
  logic load_stb, rise_stb, fall_stb, end_stb, res_stb;

  adc_phase_timer #(.DIV(DIV)) u_timer (
    .clk (clk),
    .rst (rst),
    .run (run),
    .tick(tick)
  );

  adc_frame_seq #(
    .CMD_W     (CMD_W),
    .SHORT_SAMP(SHORT_SAMP),
    .LONG_SAMP (LONG_SAMP),
    .CONV_CLKS (CONV_CLKS),
    .RES_W     (RES_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_long   (req_long),
    .req_fs_mode(req_fs_mode),
    .tick       (tick),
    .run        (run),
    .req_ready  (req_ready),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .fs         (fs),
    .load_stb   (load_stb),
    .rise_stb   (rise_stb),
    .fall_stb   (fall_stb),
    .end_stb    (end_stb),
    .res_stb    (res_stb)
  );

  adc_shift_unit #(
    .CMD_W  (CMD_W),
    .CFG_W  (CFG_W),
    .RES_W  (RES_W),
    .CFG_CMD(CFG_CMD)
  ) u_shift (
    .clk         (clk),
    .rst         (rst),
    .load_stb    (load_stb),
    .req_cmd     (req_cmd),
    .req_cfg     (req_cfg),
    .fall_stb    (fall_stb),
    .end_stb     (end_stb),
    .rise_stb    (rise_stb),
    .res_stb     (res_stb),
    .sdo         (sdo),
    .sdi         (sdi),
    .result_valid(result_valid),
    .result_data (result_data)
  );

  // R10: lines stay quiet while chip select is released
  p_idle_lines_r10: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (!sdi && !sclk));

endmodule

// File: tb/adc_frame_ctrl_bench.sv
module adc_frame_ctrl_bench;

  localparam int DIV  = 2;
  localparam int CONV = 72;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_cmd = '0;
  logic [11:0] req_cfg = '0;
  logic        req_long = 1'b0;
  logic        req_fs_mode = 1'b0;
  logic        cs_n, fs, sclk, sdi;
  logic        sdo = 1'b0;
  logic        result_valid;
  logic [13:0] result_data;

  always #4 clk = ~clk;

  adc_frame_ctrl #(.DIV(DIV), .CONV_CLKS(CONV)) u_adc_frame_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_cfg(req_cfg), .req_long(req_long),
    .req_fs_mode(req_fs_mode), .cs_n(cs_n), .fs(fs), .sclk(sclk),
    .sdi(sdi), .sdo(sdo), .result_valid(result_valid),
    .result_data(result_data)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [15:0] exp_word [32];
  int          exp_len  [32];
  logic [13:0] exp_res  [32];
  bit          exp_fs   [32];
  int nsent = 0;
  int fidx  = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor and converter model, all at the falling system clock edge
  int cyc = 0;
  bit prev_cs = 1, prev_sclk = 0, prev_ready = 1;
  int t_cs = 0, t_rise = 0, t_csr = 0;
  int nrise = 0, e4 = 0, e5 = 0, e6 = 0, e7 = 0, eidle = 0;
  int npulse = 0, pulse_at = 0;
  logic [13:0] got = '0;
  logic [15:0] conv_sh = '0;
  bit exp_bit;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (prev_cs && !cs_n) begin
        chk(fidx < nsent, "R2 frame without request", fidx, nsent);
        chk(fs == exp_fs[fidx], "R3 fs at frame start", int'(fs), int'(exp_fs[fidx]));
        t_cs = cyc; nrise = 0; e4 = 0; e5 = 0; e6 = 0; e7 = 0; npulse = 0;
        conv_sh = {exp_res[fidx], 2'b00};
        sdo = conv_sh[15];
      end
      if (!prev_sclk && sclk) begin
        if (nrise == 0) begin
          chk(cyc - t_cs == DIV, "R3 setup time", cyc - t_cs, DIV);
          chk(fs == 1'b0, "R3 fs at first edge", int'(fs), 0);
        end else if (cyc - t_rise != 2 * DIV) begin
          e7++;
        end
        t_rise = cyc;
        exp_bit = (nrise < 16) ? exp_word[fidx][15 - nrise] : 1'b0;
        if (sdi != exp_bit) begin
          if (nrise < 4) e4++;
          else if (nrise < 16) e5++;
          else e6++;
        end
        nrise++;
      end
      if (prev_sclk && !sclk && !cs_n) begin
        conv_sh = {conv_sh[14:0], 1'b0};
        sdo = conv_sh[15];
      end
      if (result_valid) begin
        npulse++;
        got = result_data;
        pulse_at = nrise;
      end
      if (!prev_cs && cs_n) begin
        chk(e4 == 0, "R4 command bits", e4, 0);
        chk(e5 == 0, "R5 config bits", e5, 0);
        chk(e6 == 0, "R6 fill bits", e6, 0);
        chk(nrise == exp_len[fidx], "R6 frame length", nrise, exp_len[fidx]);
        chk(e7 == 0, "R7 half period", e7, 0);
        chk(cyc - t_rise == DIV, "R9 release after last edge", cyc - t_rise, DIV);
        chk(npulse == 1, "R8 pulse count", npulse, 1);
        chk(pulse_at == 14, "R8 pulse position", pulse_at, 14);
        chk(got == exp_res[fidx], "R8 result value", int'(got), int'(exp_res[fidx]));
        t_csr = cyc;
        fidx++;
      end
      if (!prev_ready && req_ready) begin
        chk(cyc - t_csr == 2 * CONV * DIV, "R9 conversion wait",
            cyc - t_csr, 2 * CONV * DIV);
      end
      if (cs_n && (sclk || sdi)) eidle++;
    end
    prev_cs = cs_n; prev_sclk = sclk; prev_ready = req_ready;
  end

  task automatic send(input logic [3:0] c, input logic [11:0] g,
                      input bit lng, input bit fsm, input logic [13:0] r);
    req_cmd = c; req_cfg = g; req_long = lng; req_fs_mode = fsm;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    exp_word[nsent] = {c, (c == 4'b1010) ? g : 12'h000};
    exp_len[nsent]  = lng ? 48 : 16;
    exp_res[nsent]  = r;
    exp_fs[nsent]   = fsm;
    nsent++;
    @(negedge clk);
    req_valid = 1'b0;
    req_cmd = 4'hF; req_cfg = 12'hFFF;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R1 cs_n in reset", int'(cs_n), 1);
    chk(sclk == 1'b0, "R1 sclk in reset", int'(sclk), 0);
    chk(sdi == 1'b0, "R1 sdi in reset", int'(sdi), 0);
    chk(fs == 1'b0, "R1 fs in reset", int'(fs), 0);
    chk(result_valid == 1'b0, "R1 result_valid in reset", int'(result_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    for (int c = 0; c < 16; c++) begin
      send(4'(c), 12'(c * 291 + 17), (c % 2) == 1, ((c / 2) % 2) == 1,
           14'(c * 1093 + 77));
    end
    send(4'b1010, 12'hFFF, 1'b1, 1'b0, 14'h3FFF);
    send(4'b1010, 12'h000, 1'b0, 1'b1, 14'h0000);
    send(4'b0101, 12'hFFF, 1'b0, 1'b0, 14'h2AAA);
    send(4'b1010, 12'hA5C, 1'b1, 1'b1, 14'h1555);
    while (fidx < nsent || !req_ready) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(fidx == nsent, "R2 frames per request", fidx, nsent);
    chk(eidle == 0, "R10 quiet lines outside frame", eidle, 0);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog expired frames=%0d expected=%0d", fidx, nsent);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule